// File: doc/BRIEF.md
# Six-Stage Pipeline Forwarding and Stall Control

This block is the operand-bypass and interlock controller for an in-order integer pipeline with six stages: fetch, decode, two ALU stages (EX1 and EX2), memory, and write-back. The ALU needs two cycles. It reads its operands at the start of EX1 and has a result only once that result is registered at the end of EX2. Loaded data appears in a dedicated memory-data register when the load reaches write-back. So a consumer in EX1 can take bypassed values from three places: the EX2/MEM register, the MEM/WB register, and the memory-data register.

The logic is purely combinational. It looks at the source register numbers of the instruction now in EX1 and at the destination, write-enable and load flag of the instructions further down. From these it produces a 2-bit bypass select for each EX1 operand. It also looks at the source numbers of the instruction in decode and compares them with the producers in EX1 and EX2. When a value cannot be bypassed in time, it raises a stall request and a bubble request. The stall request freezes PC and the fetch/decode register, and the bubble request turns the EX1 entry into a no-op.

The register file writes in the first half of a cycle. A producer that has left write-back is therefore already visible to a decode-stage read, and needs no bypass path. Decode must present 0 for any source field that an instruction does not read. Every instruction that writes a register sets its write-enable, and that includes loads.

Top module: `pipe_fwd_ctrl`

## Requirements
- R1: When no downstream stage has its write-enable set, both bypass selects read 00 (register file) and neither stall nor bubble is asserted.
- R2: An operand select reads 01 when the instruction in MEM (the EX2/MEM register) writes that operand's nonzero source register.
- R3: An operand select reads 10 when the instruction in write-back is not a load, writes that source, and MEM does not.
- R4: An operand select reads 11 (memory-data register) when the instruction in write-back is a load that writes that source, and MEM does not.
- R5: When both MEM and write-back write the same source register, the younger producer in MEM wins and the select reads 01.
- R6: Register 0 is never bypassed, and a producer whose write-enable is clear is never bypassed, even when its register number matches.
- R7: The two operand selects are decided independently, each from its own source number.
- R8: A stall is raised when a nonzero decode-stage source matches the destination of a writing instruction in EX1, whether that instruction is an ALU operation or a load.
- R9: A stall is raised when a nonzero decode-stage source matches the destination of a load in EX2. A non-load in EX2 with a matching destination causes no stall.
- R10: The bubble output always equals the stall output, and a decode source of register 0 never causes a stall.
- R11: In a pipeline, a dependent sequence of add, add, add, lw, addi, add behaves as follows. Use after a load costs two stall cycles. Use right after an ALU producer costs one stall cycle. The consumers then see selects 10, 11 and 01 on the expected operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex1_rs | input | RW | First source register of the instruction in EX1 |
| ex1_rt | input | RW | Second source register of the instruction in EX1 |
| id_rs | input | RW | First source register of the instruction in decode (0 if unused) |
| id_rt | input | RW | Second source register of the instruction in decode (0 if unused) |
| ex1_rd | input | RW | Destination of the instruction in EX1 |
| ex1_we | input | 1 | Write-enable of the instruction in EX1 |
| ex2_rd | input | RW | Destination of the instruction in EX2 |
| ex2_we | input | 1 | Write-enable of the instruction in EX2 |
| ex2_load | input | 1 | Instruction in EX2 is a load |
| mem_rd | input | RW | Destination held in the EX2/MEM register |
| mem_we | input | 1 | Write-enable held in the EX2/MEM register |
| wb_rd | input | RW | Destination held in the MEM/WB register |
| wb_we | input | 1 | Write-enable held in the MEM/WB register |
| wb_load | input | 1 | Instruction in MEM/WB is a load (data in memory-data register) |
| fwd_sel_a | output | 2 | Bypass select for the first EX1 operand |
| fwd_sel_b | output | 2 | Bypass select for the second EX1 operand |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Turn the EX1 entry into a no-op |

## Verification
Every output is combinational, so every result is due in the same cycle as the inputs that cause it. The bench drives the inputs just after a falling edge and samples 1 ns later, well before the next rising edge. In the pipeline model, a stall shows its effect only one cycle later: the decode entry stays put and EX1 holds a bubble. The model therefore applies the stall it expects for the sampled cycle at the following edge. It then checks the selects on the cycle in which each real instruction occupies EX1.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EXM = 2'b01,
    SEL_MW  = 2'b10,
    SEL_MDR = 2'b11
  } fwd_sel_e;

  // Youngest matching producer wins; an older match picks ALU result or load data.
  function automatic fwd_sel_e pick_sel(input logic young_hit,
                                        input logic old_hit,
                                        input logic old_is_load);
    if (young_hit)    return SEL_EXM;
    else if (old_hit) return old_is_load ? SEL_MDR : SEL_MW;
    else              return SEL_RF;
  endfunction

endpackage

// File: rtl/pfc_hit.sv
module pfc_hit #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] rd,
  input  logic          we,
  output logic          hit
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  assign hit = we && (rd != ZERO_REG) && (rd == src);
endmodule

// File: rtl/pfc_operand_sel.sv
module pfc_operand_sel
  import pfc_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          wb_load,
  output logic [1:0]    sel
);
  logic mem_hit;
  logic wb_hit;

  pfc_hit #(.RW(RW)) u_mem_hit (.src(src), .rd(mem_rd), .we(mem_we), .hit(mem_hit));
  pfc_hit #(.RW(RW)) u_wb_hit  (.src(src), .rd(wb_rd),  .we(wb_we),  .hit(wb_hit));

  always_comb begin
    sel = pick_sel(mem_hit, wb_hit, wb_load);
  end
endmodule

// File: rtl/pfc_hazard.sv
module pfc_hazard #(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic [RW-1:0] id_src [NSRC],
  input  logic [RW-1:0] ex1_rd,
  input  logic          ex1_we,
  input  logic [RW-1:0] ex2_rd,
  input  logic          ex2_we,
  input  logic          ex2_load,
  output logic          stall_req
);
  logic [NSRC-1:0] near_hit;
  logic [NSRC-1:0] load_hit;
  logic            ex2_load_we;

  assign ex2_load_we = ex2_we & ex2_load;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // Any writer in EX1 is one cycle too close for an EX1 bypass.
    pfc_hit #(.RW(RW)) u_near (.src(id_src[i]), .rd(ex1_rd), .we(ex1_we),      .hit(near_hit[i]));
    // Load data is not ready until the load sits in write-back.
    pfc_hit #(.RW(RW)) u_load (.src(id_src[i]), .rd(ex2_rd), .we(ex2_load_we), .hit(load_hit[i]));
  end

  assign stall_req = |(near_hit | load_hit);
endmodule

// File: rtl/pipe_fwd_ctrl.sv
module pipe_fwd_ctrl
  import pfc_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex1_rs,
  input  logic [RW-1:0] ex1_rt,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [RW-1:0] ex1_rd,
  input  logic          ex1_we,
  input  logic [RW-1:0] ex2_rd,
  input  logic          ex2_we,
  input  logic          ex2_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          wb_load,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic          stall,
  output logic          bubble
);
  localparam int NOPS = 2;

  logic [RW-1:0] ex1_src [NOPS];
  logic [RW-1:0] id_src  [NOPS];
  logic [1:0]    op_sel  [NOPS];
  logic          stall_req;

  assign ex1_src[0] = ex1_rs;
  assign ex1_src[1] = ex1_rt;
  assign id_src[0]  = id_rs;
  assign id_src[1]  = id_rt;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    pfc_operand_sel #(.RW(RW)) u_sel (
      .src     (ex1_src[i]),
      .mem_rd  (mem_rd),
      .mem_we  (mem_we),
      .wb_rd   (wb_rd),
      .wb_we   (wb_we),
      .wb_load (wb_load),
      .sel     (op_sel[i])
    );
  end

  pfc_hazard #(.RW(RW), .NSRC(NOPS)) u_haz (
    .id_src    (id_src),
    .ex1_rd    (ex1_rd),
    .ex1_we    (ex1_we),
    .ex2_rd    (ex2_rd),
    .ex2_we    (ex2_we),
    .ex2_load  (ex2_load),
    .stall_req (stall_req)
  );

  assign fwd_sel_a = op_sel[0];
  assign fwd_sel_b = op_sel[1];
  assign stall     = stall_req;
  assign bubble    = stall_req;
endmodule

// File: rtl/pipe_fwd_ctrl_chk.sv
module pipe_fwd_ctrl_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] ex1_rs,
  input logic [RW-1:0] ex1_rt,
  input logic [RW-1:0] ex1_rd,
  input logic          ex1_we,
  input logic          ex2_we,
  input logic          ex2_load,
  input logic [RW-1:0] mem_rd,
  input logic          mem_we,
  input logic [RW-1:0] wb_rd,
  input logic          wb_we,
  input logic          wb_load,
  input logic [1:0]    fwd_sel_a,
  input logic [1:0]    fwd_sel_b,
  input logic          stall,
  input logic          bubble
);
  logic known;
  assign known = !$isunknown({ex1_rs, ex1_rt, ex1_rd, ex1_we, ex2_we, ex2_load, mem_rd, mem_we,
                              wb_rd, wb_we, wb_load, fwd_sel_a, fwd_sel_b, stall, bubble});

  always_comb begin
    if (known) begin
      // R6
      zero_src_chk: assert (!((fwd_sel_a != 2'b00) && (ex1_rs == '0)) && !((fwd_sel_b != 2'b00) && (ex1_rt == '0)))
        else $error("bypass selected for register 0");
      // R2
      mem_src_chk: assert (!(fwd_sel_a == 2'b01) || (mem_we && mem_rd == ex1_rs))
        else $error("select 01 without a matching MEM producer");
      // R4
      mdr_src_chk: assert (!(fwd_sel_b == 2'b11) || (wb_we && wb_load && wb_rd == ex1_rt))
        else $error("select 11 without a matching load in write-back");
      // R3
      wb_alu_chk: assert (!(fwd_sel_a == 2'b10) || (wb_we && !wb_load && wb_rd == ex1_rs))
        else $error("select 10 without a matching non-load in write-back");
      // R10
      bubble_eq_chk: assert (bubble == stall)
        else $error("bubble and stall disagree");
      // R9
      quiet_chk: assert (ex1_we || (ex2_we && ex2_load) || !stall)
        else $error("stall with no EX1 writer and no EX2 load");
    end
  end
endmodule

bind pipe_fwd_ctrl pipe_fwd_ctrl_chk #(.RW(RW)) u_chk (.*);

// File: tb/pipe_fwd_ctrl_bench.sv
module pipe_fwd_ctrl_bench;
  localparam int RW = 5;
  localparam int NI = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [RW-1:0] ex1_rs, ex1_rt, id_rs, id_rt, ex1_rd, ex2_rd, mem_rd, wb_rd;
  logic ex1_we, ex2_we, ex2_load, mem_we, wb_we, wb_load;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic stall, bubble;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pipe_fwd_ctrl #(.RW(RW)) u_pipe_fwd_ctrl (.*);

  // Program: add, add, add, lw, addi, add (src 0 means unused)
  int p_rd [NI] = '{8, 10, 13, 12, 11, 9};
  int p_s1 [NI] = '{8, 10, 9, 8, 12, 10};
  int p_s2 [NI] = '{9, 11, 11, 0, 0, 11};
  int p_ld [NI] = '{0, 0, 0, 1, 0, 0};
  int x_a  [NI] = '{0, 0, 0, 2, 3, 0};
  int x_b  [NI] = '{0, 0, 0, 0, 0, 1};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    {ex1_rs, ex1_rt, id_rs, id_rt, ex1_rd, ex2_rd, mem_rd, wb_rd} = '0;
    {ex1_we, ex2_we, ex2_load, mem_we, wb_we, wb_load} = '0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drive_stage(input int s_id, input int s_ex1, input int s_ex2,
                             input int s_mem, input int s_wb);
    clr();
    if (s_id >= 0)  begin id_rs = RW'(p_s1[s_id]); id_rt = RW'(p_s2[s_id]); end
    if (s_ex1 >= 0) begin ex1_rs = RW'(p_s1[s_ex1]); ex1_rt = RW'(p_s2[s_ex1]);
                          ex1_rd = RW'(p_rd[s_ex1]); ex1_we = 1'b1; end
    if (s_ex2 >= 0) begin ex2_rd = RW'(p_rd[s_ex2]); ex2_we = 1'b1; ex2_load = p_ld[s_ex2] != 0; end
    if (s_mem >= 0) begin mem_rd = RW'(p_rd[s_mem]); mem_we = 1'b1; end
    if (s_wb >= 0)  begin wb_rd = RW'(p_rd[s_wb]); wb_we = 1'b1; wb_load = p_ld[s_wb] != 0; end
  endtask

  // Behavioural reference: a source waits while its producer is one stage ahead,
  // or two stages ahead and still fetching its data from memory.
  function automatic bit ref_stall(input int s_id, input int s_ex1, input int s_ex2);
    bit w = 1'b0;
    if (s_id < 0) return 1'b0;
    for (int d = 1; d <= 2; d++) begin
      int pr = (d == 1) ? s_ex1 : s_ex2;
      if (pr >= 0 && p_rd[pr] != 0 && (d == 1 || p_ld[pr] != 0))
        if (p_rd[pr] == p_s1[s_id] || p_rd[pr] == p_s2[s_id]) w = 1'b1;
    end
    return w;
  endfunction

  initial begin
    rst_n = 1'b0;
    clr();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R1 idle
    @(negedge clk); clr(); ex1_rs = 5; ex1_rt = 6; id_rs = 5; ex1_rd = 5; mem_rd = 5; wb_rd = 6; settle();
    check("R1 sel_a idle", fwd_sel_a, 0);
    check("R1 sel_b idle", fwd_sel_b, 0);
    check("R1 stall idle", stall, 0);
    check("R1 bubble idle", bubble, 0);

    // R2
    @(negedge clk); clr(); ex1_rs = 5; mem_rd = 5; mem_we = 1; settle();
    check("R2 sel_a from EX2/MEM", fwd_sel_a, 1);
    check("R2 sel_b untouched", fwd_sel_b, 0);

    // R3
    @(negedge clk); clr(); ex1_rt = 7; wb_rd = 7; wb_we = 1; settle();
    check("R3 sel_b from MEM/WB", fwd_sel_b, 2);

    // R4
    @(negedge clk); wb_load = 1; settle();
    check("R4 sel_b from load data", fwd_sel_b, 3);

    // R5
    @(negedge clk); clr(); ex1_rs = 5; mem_rd = 5; mem_we = 1; wb_rd = 5; wb_we = 1; wb_load = 1; settle();
    check("R5 youngest wins", fwd_sel_a, 1);

    // R6
    @(negedge clk); clr(); mem_we = 1; wb_we = 1; settle();
    check("R6 reg0 sel_a", fwd_sel_a, 0);
    check("R6 reg0 sel_b", fwd_sel_b, 0);
    @(negedge clk); clr(); ex1_rs = 9; mem_rd = 9; wb_rd = 9; settle();
    check("R6 write-enable low", fwd_sel_a, 0);

    // R7
    @(negedge clk); clr(); ex1_rs = 5; ex1_rt = 6; mem_rd = 5; mem_we = 1;
    wb_rd = 6; wb_we = 1; wb_load = 1; settle();
    check("R7 sel_a independent", fwd_sel_a, 1);
    check("R7 sel_b independent", fwd_sel_b, 3);

    // R8
    @(negedge clk); clr(); id_rs = 3; ex1_rd = 3; ex1_we = 1; settle();
    check("R8 ALU in EX1 stall", stall, 1);
    check("R10 bubble follows stall", bubble, 1);
    @(negedge clk); clr(); id_rt = 4; ex1_rd = 4; ex1_we = 1; settle();
    check("R8 rt match stall", stall, 1);

    // R9
    @(negedge clk); clr(); id_rt = 3; ex2_rd = 3; ex2_we = 1; ex2_load = 1; settle();
    check("R9 load in EX2 stall", stall, 1);
    @(negedge clk); ex2_load = 0; settle();
    check("R9 ALU in EX2 no stall", stall, 0);

    // R10
    @(negedge clk); clr(); ex1_we = 1; ex2_we = 1; ex2_load = 1; settle();
    check("R10 reg0 no stall", stall, 0);
    check("R10 bubble low", bubble, 0);

    // R11 pipeline model
    begin
      int s_id = -1, s_ex1 = -1, s_ex2 = -1, s_mem = -1, s_wb = -1;
      int pc = 0;
      int st_total = 0, st_i4 = 0, st_i5 = 0;
      for (int cyc = 0; cyc < 20; cyc++) begin
        bit want;
        @(negedge clk);
        drive_stage(s_id, s_ex1, s_ex2, s_mem, s_wb);
        settle();
        want = ref_stall(s_id, s_ex1, s_ex2);
        if (stall !== want || bubble !== want) begin
          check("R11 stall per cycle", {stall, bubble}, {want, want});
        end else n_run++;
        if (s_ex1 >= 0) begin
          check("R11 sel_a in EX1", fwd_sel_a, 8'(x_a[s_ex1]));
          check("R11 sel_b in EX1", fwd_sel_b, 8'(x_b[s_ex1]));
        end
        if (want) begin
          st_total++;
          if (s_id == 4) st_i4++;
          if (s_id == 5) st_i5++;
        end
        s_wb = s_mem; s_mem = s_ex2; s_ex2 = s_ex1;
        if (want) s_ex1 = -1;
        else begin
          s_ex1 = s_id;
          s_id = (pc < NI) ? pc : -1;
          pc++;
        end
      end
      check("R11 load-use stalls", 8'(st_i4), 2);
      check("R11 ALU-use stalls", 8'(st_i5), 1);
      check("R11 total stalls", 8'(st_total), 3);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule